// File: doc/BRIEF.md
# Phase-Synchronized Configuration Write Stall

This block sits between a processor's I/O write port and a bank of switched-capacitor configuration registers. An analog column runs on two non-overlapping phase clocks, and a configuration register that changes while the circuit is settling can glitch the analog output. The best moment to update such a register is the start of phase 1. The processor, however, can issue a write on any master clock edge in either phase.

When synchronization is enabled, the block holds back any write aimed at the switched-capacitor address window and stalls the processor. It captures the address and data of that write. It then applies the write on the first phase-1 rising edge seen after the write was accepted, and releases the stall in that same cycle. The enable is a single bit in a local control register, and the processor writes it through the same port. Writes to any other address, and every write while the enable is clear, go straight through with no stall.

The block also produces a one-cycle column interrupt pulse when phase 2 falls, which is the same moment that phase 1 begins. Software can use this pulse to time its writes instead of relying on the stall. Both phase signals are inputs already synchronous to the master clock. The block finds their edges by comparing each sample with a copy delayed by one cycle.

Top module: `sc_write_sync`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cpu_stall_o`, `reg_wr_o` and `col_irq_o` are low. The synchronization enable resets to 0, so a write to the window right after reset passes through unstalled.
- R2: A write to address 0xC3 loads the enable from data bit 0 and ignores the other data bits. This write is never forwarded, so `reg_wr_o` stays low in the following cycle.
- R3: While the enable is 0, a write to any address other than 0xC3, including the window 0x80 to 0x9F, never raises `cpu_stall_o`. In the cycle after the write is presented, `reg_wr_o` is 1 and the output address and data equal the presented values.
- R4: While the enable is 1, a write outside the window 0x80 to 0x9F (and not to 0xC3) is forwarded exactly as in R3, with no stall.
- R5: While the enable is 1, a write to the window 0x80 to 0x9F raises `cpu_stall_o` combinationally in the cycle it is presented. The stall stays high in every following cycle until the release cycle.
- R6: A phase-1 rising edge is a clock edge at which `phi1_i` is sampled 1 after being sampled 0 at the previous edge. The release cycle is the one ending in the first such edge after the accepting edge. In that cycle `cpu_stall_o` is low. In the next cycle `reg_wr_o` is 1 and carries the captured address and data.
- R7: A phase-1 rising edge at the very edge that accepts a held write does not release it. The write waits for the next phase-1 rising edge.
- R8: A held write produces exactly one `reg_wr_o` strobe. No strobe appears in any cycle that follows a cycle with the stall high.
- R9: `col_irq_o` is high for exactly one cycle, namely the cycle after the clock edge at which `phi2_i` is first sampled 0 following a sample of 1.
- R10: With no write pending, phase-1 edges produce no `reg_wr_o` strobe and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_i | input | 1 | Processor write request, held while stalled |
| cpu_addr_i | input | 8 | Processor write address |
| cpu_data_i | input | 8 | Processor write data |
| cpu_stall_o | output | 1 | Stall to the processor, combinational |
| phi1_i | input | 1 | Phase-1 level, sampled in the master domain |
| phi2_i | input | 1 | Phase-2 level, sampled in the master domain |
| reg_wr_o | output | 1 | Write strobe to the configuration registers |
| reg_addr_o | output | 8 | Address of the write being applied |
| reg_data_o | output | 8 | Data of the write being applied |
| col_irq_o | output | 1 | One-cycle pulse after a phase-2 falling edge |

## Verification
The assertions assume that the processor keeps its write request, address and data steady while the stall is high, and drops or changes them only in the cycle after the stall falls. They also assume that both phase inputs are already synchronous to the master clock. The stimulus keeps to these assumptions in every write task: each task holds the write until it observes the stall low away from the clock edge, then removes the write at the next falling clock edge. Phase levels likewise change only on falling clock edges. Under those conditions the checks cover four points: the stall never coexists with a clear enable, a held write always enters the hold state even when a phase-1 edge coincides with it, the release cycle is always followed by a strobe carrying the captured address, and the interrupt never lasts two cycles.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wreq_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_CTRL = 2'd1,
        WK_SC   = 2'd2,
        WK_PASS = 2'd3
    } wkind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hstate_e;

    function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/wsync_edge_det.sv
module wsync_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic edge_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sig_i & ~sig_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & sig_q;
        end
    endgenerate
endmodule

// File: rtl/wsync_decode.sv
module wsync_decode
    import wsync_pkg::*;
#(
    parameter addr_t SC_LO     = 8'h80,
    parameter addr_t SC_HI     = 8'h9F,
    parameter addr_t CTRL_ADDR = 8'hC3
) (
    input  logic   wr_i,
    input  addr_t  addr_i,
    output wkind_e kind_o
);
    always_comb begin
        if (!wr_i)                            kind_o = WK_NONE;
        else if (addr_i == CTRL_ADDR)         kind_o = WK_CTRL;
        else if (in_window(addr_i, SC_LO, SC_HI)) kind_o = WK_SC;
        else                                  kind_o = WK_PASS;
    end
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic we_i,
    input  logic en_bit_i,
    output logic en_o
);
    always_ff @(posedge clk) begin
        if (rst)       en_o <= 1'b0;
        else if (we_i) en_o <= en_bit_i;
    end
endmodule

// File: rtl/wsync_hold.sv
module wsync_hold
    import wsync_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wkind_e kind_i,
    input  wreq_t  req_i,
    input  logic   en_i,
    input  logic   phi1_rise_i,
    output logic   stall_o,
    output logic   out_vld_o,
    output wreq_t  out_req_o,
    output logic   hold_o,
    output wreq_t  held_o
);
    hstate_e st_q;
    wreq_t   held_q;
    logic    take, pass, rel;

    always_comb begin
        take    = (st_q == ST_IDLE) && (kind_i == WK_SC) && en_i;
        pass    = (st_q == ST_IDLE) &&
                  ((kind_i == WK_PASS) || ((kind_i == WK_SC) && !en_i));
        rel     = (st_q == ST_HOLD) && phi1_rise_i;
        stall_o = take || ((st_q == ST_HOLD) && !phi1_rise_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            held_q    <= '0;
            out_vld_o <= 1'b0;
            out_req_o <= '0;
        end else begin
            if (take)     st_q <= ST_HOLD;
            else if (rel) st_q <= ST_IDLE;
            if (take) held_q <= req_i;
            out_vld_o <= pass || rel;
            if (rel)       out_req_o <= held_q;
            else if (pass) out_req_o <= req_i;
        end
    end

    assign hold_o = (st_q == ST_HOLD);
    assign held_o = held_q;
endmodule

// File: rtl/sc_write_sync.sv
module sc_write_sync
    import wsync_pkg::*;
#(
    parameter addr_t SC_LO     = 8'h80,
    parameter addr_t SC_HI     = 8'h9F,
    parameter addr_t CTRL_ADDR = 8'hC3,
    parameter int    EN_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_data_i,
    output logic              cpu_stall_o,
    input  logic              phi1_i,
    input  logic              phi2_i,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_data_o,
    output logic              col_irq_o
);
    wkind_e kind;
    wreq_t  req, out_req, held;
    logic   sync_en, hold_active, phi1_rise, phi2_fall, ctrl_we;
    addr_t  held_addr;

    assign req = '{addr: cpu_addr_i, data: cpu_data_i};

    wsync_decode #(.SC_LO(SC_LO), .SC_HI(SC_HI), .CTRL_ADDR(CTRL_ADDR)) dec_i (
        .wr_i   (cpu_wr_i),
        .addr_i (cpu_addr_i),
        .kind_o (kind)
    );

    assign ctrl_we = (kind == WK_CTRL) && !hold_active;

    wsync_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .we_i     (ctrl_we),
        .en_bit_i (cpu_data_i[EN_BIT]),
        .en_o     (sync_en)
    );

    wsync_edge_det #(.RISING(1'b1)) ph1_i (
        .clk (clk), .rst (rst), .sig_i (phi1_i), .edge_o (phi1_rise)
    );

    wsync_edge_det #(.RISING(1'b0)) ph2_i (
        .clk (clk), .rst (rst), .sig_i (phi2_i), .edge_o (phi2_fall)
    );

    wsync_hold hold_i (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind),
        .req_i       (req),
        .en_i        (sync_en),
        .phi1_rise_i (phi1_rise),
        .stall_o     (cpu_stall_o),
        .out_vld_o   (reg_wr_o),
        .out_req_o   (out_req),
        .hold_o      (hold_active),
        .held_o      (held)
    );

    assign held_addr  = held.addr;
    assign reg_addr_o = out_req.addr;
    assign reg_data_o = out_req.data;

    always_ff @(posedge clk) begin
        if (rst) col_irq_o <= 1'b0;
        else     col_irq_o <= phi2_fall;
    end
endmodule

// File: rtl/wsync_chk.sv
module wsync_chk
    import wsync_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cpu_stall_o,
    input logic  reg_wr_o,
    input addr_t reg_addr_o,
    input logic  col_irq_o,
    input logic  en_q,
    input logic  hold_q,
    input addr_t held_addr
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!reg_wr_o && !col_irq_o && !hold_q)); // R1

    AST_STALL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        cpu_stall_o |-> en_q); // R3

    AST_TAKE_ENTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && cpu_stall_o) |=> hold_q); // R5

    AST_SAME_EDGE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && cpu_stall_o) |=> !reg_wr_o); // R7

    AST_RELEASE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !cpu_stall_o) |=> (reg_wr_o && (reg_addr_o == $past(held_addr)))); // R6

    AST_NO_STROBE_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        cpu_stall_o |=> !reg_wr_o); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        col_irq_o |=> !col_irq_o); // R9
endmodule

bind sc_write_sync wsync_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_stall_o (cpu_stall_o),
    .reg_wr_o    (reg_wr_o),
    .reg_addr_o  (reg_addr_o),
    .col_irq_o   (col_irq_o),
    .en_q        (sync_en),
    .hold_q      (hold_active),
    .held_addr   (held_addr)
);

// File: tb/sc_write_sync_tb_top.sv
module sc_write_sync_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr_i = 1'b0;
    logic [7:0] cpu_addr_i = '0;
    logic [7:0] cpu_data_i = '0;
    logic       cpu_stall_o;
    logic       phi1_i = 1'b0;
    logic       phi2_i = 1'b0;
    logic       reg_wr_o;
    logic [7:0] reg_addr_o;
    logic [7:0] reg_data_o;
    logic       col_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_write_sync dut_i (.*);

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] dly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 8'h80, 8'h11, 4'd0},
        '{1'b1, 8'h80, 8'h22, 4'd0},
        '{1'b1, 8'h9F, 8'h33, 4'd3},
        '{1'b1, 8'h7F, 8'h44, 4'd0},
        '{1'b1, 8'hA0, 8'h55, 4'd0},
        '{1'b0, 8'h9F, 8'h66, 4'd2},
        '{1'b1, 8'h8C, 8'hA5, 4'd5},
        '{1'b1, 8'h00, 8'hFF, 4'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_sc(input logic [7:0] a);
        return (a >= 8'h80) && (a <= 8'h9F);
    endfunction

    task automatic ctrl_write(input logic en);
        @(negedge clk);
        cpu_wr_i = 1'b1; cpu_addr_i = 8'hC3;
        cpu_data_i = en ? 8'h01 : 8'hFE;
        #1 check(cpu_stall_o == 1'b0, "R2 ctrl stall", cpu_stall_o, 0);
        @(negedge clk);
        cpu_wr_i = 1'b0;
        check(reg_wr_o == 1'b0, "R2 ctrl not forwarded", reg_wr_o, 0);
    endtask

    task automatic pass_write(input logic [7:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
        #1 check(cpu_stall_o == 1'b0, {req, " no stall"}, cpu_stall_o, 0);
        @(negedge clk);
        cpu_wr_i = 1'b0;
        check(reg_wr_o == 1'b1, {req, " strobe"}, reg_wr_o, 1);
        check(reg_addr_o == a, {req, " addr"}, reg_addr_o, a);
        check(reg_data_o == d, {req, " data"}, reg_data_o, d);
        @(negedge clk);
        check(reg_wr_o == 1'b0, {req, " single strobe"}, reg_wr_o, 0);
    endtask

    task automatic held_write(input logic [7:0] a, input logic [7:0] d, input int dly);
        @(negedge clk);
        phi1_i = 1'b0;
        cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
        #1 check(cpu_stall_o == 1'b1, "R5 stall at issue", cpu_stall_o, 1);
        @(negedge clk);
        check(cpu_stall_o == 1'b1, "R5 stall held", cpu_stall_o, 1);
        check(reg_wr_o == 1'b0, "R8 no early strobe", reg_wr_o, 0);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check(cpu_stall_o == 1'b1, "R5 stall waiting", cpu_stall_o, 1);
            check(reg_wr_o == 1'b0, "R8 no strobe waiting", reg_wr_o, 0);
        end
        phi1_i = 1'b1;
        #1 check(cpu_stall_o == 1'b0, "R6 stall low in release cycle", cpu_stall_o, 0);
        @(negedge clk);
        cpu_wr_i = 1'b0;
        check(reg_wr_o == 1'b1, "R6 release strobe", reg_wr_o, 1);
        check(reg_addr_o == a, "R6 release addr", reg_addr_o, a);
        check(reg_data_o == d, "R6 release data", reg_data_o, d);
        @(negedge clk);
        check(reg_wr_o == 1'b0, "R8 exactly one strobe", reg_wr_o, 0);
        check(cpu_stall_o == 1'b0, "R6 stall stays low", cpu_stall_o, 0);
        phi1_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_stall_o == 1'b0, "R1 stall in reset", cpu_stall_o, 0);
        check(reg_wr_o == 1'b0, "R1 strobe in reset", reg_wr_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_stall_o == 1'b0, "R1 stall after reset", cpu_stall_o, 0);
        check(reg_wr_o == 1'b0, "R1 strobe after reset", reg_wr_o, 0);
        check(col_irq_o == 1'b0, "R1 irq after reset", col_irq_o, 0);
        pass_write(8'h85, 8'h3C, "R1 enable clear after reset");

        for (int i = 0; i < 8; i++) begin
            ctrl_write(VECS[i].en);
            if (VECS[i].en && in_sc(VECS[i].addr))
                held_write(VECS[i].addr, VECS[i].data, int'(VECS[i].dly));
            else if (VECS[i].en)
                pass_write(VECS[i].addr, VECS[i].data, "R4 outside window");
            else
                pass_write(VECS[i].addr, VECS[i].data, "R3 enable clear");
        end

        // R7: phase-1 rise on the accepting edge
        ctrl_write(1'b1);
        @(negedge clk);
        cpu_wr_i = 1'b1; cpu_addr_i = 8'h90; cpu_data_i = 8'h5A; phi1_i = 1'b1;
        #1 check(cpu_stall_o == 1'b1, "R7 stall at coincident issue", cpu_stall_o, 1);
        @(negedge clk);
        check(cpu_stall_o == 1'b1, "R7 not released on same edge", cpu_stall_o, 1);
        check(reg_wr_o == 1'b0, "R7 no strobe on same edge", reg_wr_o, 0);
        @(negedge clk);
        check(cpu_stall_o == 1'b1, "R7 phase high no edge", cpu_stall_o, 1);
        phi1_i = 1'b0;
        @(negedge clk);
        check(cpu_stall_o == 1'b1, "R7 still waiting", cpu_stall_o, 1);
        phi1_i = 1'b1;
        #1 check(cpu_stall_o == 1'b0, "R7 release at next edge", cpu_stall_o, 0);
        @(negedge clk);
        cpu_wr_i = 1'b0;
        check(reg_wr_o == 1'b1, "R7 strobe", reg_wr_o, 1);
        check(reg_data_o == 8'h5A, "R7 data", reg_data_o, 8'h5A);
        @(negedge clk);
        check(reg_wr_o == 1'b0, "R8 single strobe after R7", reg_wr_o, 0);
        phi1_i = 1'b0;

        // R10: phase-1 edges with nothing pending
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            phi1_i = ~phi1_i;
            check(reg_wr_o == 1'b0, "R10 no strobe", reg_wr_o, 0);
            #1 check(cpu_stall_o == 1'b0, "R10 no stall", cpu_stall_o, 0);
        end
        phi1_i = 1'b0;

        // R9: column interrupt on phase-2 fall
        @(negedge clk);
        phi2_i = 1'b1;
        @(negedge clk);
        check(col_irq_o == 1'b0, "R9 no irq on rise", col_irq_o, 0);
        @(negedge clk);
        check(col_irq_o == 1'b0, "R9 no irq while high", col_irq_o, 0);
        phi2_i = 1'b0;
        @(negedge clk);
        check(col_irq_o == 1'b1, "R9 irq after fall", col_irq_o, 1);
        @(negedge clk);
        check(col_irq_o == 1'b0, "R9 irq one cycle", col_irq_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule